// File: doc/BRIEF.md
# Boot-Aware Chip-Select Decoder

This block drives eight active-low chip selects for an external memory bus. Each select has a base register, a mask register with a valid flag, and a control register. The control register holds the port width, the byte-enable mode, the automatic-acknowledge enable and a wait-state count. A transfer start is decoded against the valid selects. The chosen select is then held low, together with byte enables and a lane-size code, until the transfer is acknowledged. That acknowledge comes from an internal wait counter or from an external acknowledge input.

Select 0 starts out as a global boot select. Until software sets its valid flag, it claims every transfer whatever the address, and selects 1 to 7 stay locked. Its width, byte-enable mode and acknowledge setting come from strap levels on the data bus while reset is held, so a boot memory can be read before any register is written. Splitting a wide transfer into several narrow cycles is left to the bus master.

Top module: `csel_boot_decoder`

## Requirements
- R1: After reset, and while select 0 is not valid, every accepted transfer asserts `cs_n[0]` whatever the address.
- R2: No select among 1..7 asserts before select 0's valid flag has been written to 1, even if that select is configured and valid.
- R3: A valid select matches when `xfer_addr[31:16]` and its base agree in every bit where the mask holds 0. Once select 0 is valid, select 0 obeys this rule like the others, and a transfer that no select matches asserts nothing and is never acknowledged.
- R4: When several valid selects match, only the lowest-numbered one asserts, and at most one `cs_n` bit is ever low.
- R5: The configuration write port is `cfg_we`, `cfg_sel`, `cfg_field`, `cfg_wdata`. Field 0 writes the base from `cfg_wdata[15:0]`. Field 1 writes the mask from `cfg_wdata[15:0]` and the valid flag from `cfg_wdata[16]`. Field 2 writes control: bits [1:0] port width, bit 2 byte enables on reads, bit 3 auto-acknowledge, bits [7:4] wait states.
- R6: Select 0's control is loaded while `rst_n` is low, from the straps. `strap_d[6:5]` sets the width. `strap_d[3]` sets byte enables on reads. `strap_d[7]`=1 enables auto-acknowledge with 15 wait states, and `strap_d[7]`=0 makes select 0 wait for `ext_ack`.
- R7: Width code 00 is 32-bit, 01 is 8-bit, 10 is 16-bit, and 11 acts as 32-bit. `lane_size` shows the effective code (11 shown as 00) while a select is asserted.
- R8: `be_n[i]` is low for lane i, where lane 0 is D[31:24] and lane 3 is D[7:0]. An 8-bit port uses lane 0 only. A 16-bit port uses lane `addr[0]` for byte transfers (`xfer_size` 01) and lanes 0-1 otherwise. A 32-bit port uses lane `addr[1:0]` for bytes, lanes 0-1 or 2-3 by `addr[1]` for 16-bit transfers (`xfer_size` 10), and all four for 32-bit transfers (00). On reads with the read byte-enable bit clear, all of `be_n` stays high.
- R9: With auto-acknowledge on and W wait states, `ack` is high for exactly one clock, W clocks after the first clock in which the select is asserted. The select and byte enables release in the clock after `ack`.
- R10: With auto-acknowledge off, `ack` follows `ext_ack` while a select is asserted and stays low when no transfer is in progress.
- R11: A transfer start arriving while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_d | input | 8 | Data-bus levels seen during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Select addressed by the write |
| cfg_field | input | 2 | 0 base, 1 mask/valid, 2 control |
| cfg_wdata | input | 32 | Write data |
| xfer_start | input | 1 | One-clock transfer-start strobe |
| xfer_read | input | 1 | 1 read, 0 write |
| xfer_size | input | 2 | Transfer width, same code as the port width |
| xfer_addr | input | 32 | Transfer address |
| ext_ack | input | 1 | External acknowledge for selects without auto-acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| be_n | output | 4 | Active-low byte enables, bit i for lane i |
| lane_size | output | 2 | Port width code of the active select |
| ack | output | 1 | Transfer acknowledge |

## Verification
A corrupted base, mask or valid flag shows up in the first transfer after it: the wrong `cs_n` bit falls one clock after the start, or the locked selects open too early. A wrong captured strap or control field shows in the same clock through `lane_size` and `be_n`. A fault in the wait counter shows only at the end of the transfer, as an `ack` that comes earlier or later than the programmed count, up to sixteen clocks after the start.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    PW_32  = 2'b00,
    PW_8   = 2'b01,
    PW_16  = 2'b10,
    PW_RSV = 2'b11
  } port_width_e;

  typedef struct packed {
    logic [3:0] waits;
    logic       auto_ack;
    logic       be_on_read;
    logic [1:0] width;
  } sel_ctrl_t;

  localparam int CTRL_W = $bits(sel_ctrl_t);

  // lanes touched: bit i = lane i (lane 0 is the most significant byte)
  function automatic logic [3:0] lane_mask(input logic [1:0] width,
                                           input logic [1:0] xsize,
                                           input logic [1:0] alo);
    logic [3:0] m;
    case (width)
      PW_8:  m = 4'b0001;
      PW_16: m = (xsize == PW_8) ? (alo[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: begin
        case (xsize)
          PW_8:    m = 4'b0001 << alo;
          PW_16:   m = alo[1] ? 4'b1100 : 4'b0011;
          default: m = 4'b1111;
        endcase
      end
    endcase
    return m;
  endfunction

  function automatic logic [1:0] width_code(input logic [1:0] width);
    return (width == PW_RSV) ? PW_32 : width;
  endfunction

  function automatic sel_ctrl_t boot_ctrl(input logic [7:0] straps);
    sel_ctrl_t c;
    c.width      = straps[6:5];
    c.be_on_read = straps[3];
    c.auto_ack   = straps[7];
    c.waits      = 4'hF;
    return c;
  endfunction

endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int BW   = 16,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               strap_d,
  input  logic                     cfg_we,
  input  logic [SW-1:0]            cfg_sel,
  input  logic [1:0]               cfg_field,
  input  logic [31:0]              cfg_wdata,
  output logic [NSEL-1:0][BW-1:0]  base,
  output logic [NSEL-1:0][BW-1:0]  mask,
  output logic [NSEL-1:0]          valid,
  output sel_ctrl_t [NSEL-1:0]     ctrl
);

  localparam sel_ctrl_t CTRL_RST = '{waits: 4'hF, auto_ack: 1'b1,
                                     be_on_read: 1'b1, width: PW_32};

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic hit_w;
    assign hit_w = cfg_we && (int'(cfg_sel) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base[g]  <= '0;
        mask[g]  <= '0;
        valid[g] <= 1'b0;
        if (g == 0) ctrl[g] <= boot_ctrl(strap_d);
        else        ctrl[g] <= CTRL_RST;
      end else if (hit_w) begin
        case (cfg_field)
          2'd0: base[g] <= cfg_wdata[BW-1:0];
          2'd1: begin
            mask[g]  <= cfg_wdata[BW-1:0];
            valid[g] <= cfg_wdata[BW];
          end
          2'd2: ctrl[g] <= sel_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/csd_match.sv
module csd_match #(
  parameter int NSEL = 8,
  parameter int BW   = 16,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic [BW-1:0]            upper,
  input  logic [NSEL-1:0][BW-1:0]  base,
  input  logic [NSEL-1:0][BW-1:0]  mask,
  input  logic [NSEL-1:0]          valid,
  output logic                     hit_any,
  output logic [SW-1:0]            hit_idx,
  output logic                     boot_mode
);

  function automatic logic in_range(input logic [BW-1:0] a,
                                    input logic [BW-1:0] b,
                                    input logic [BW-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  logic [NSEL-1:0] raw_hit;
  logic [NSEL-1:0] eff_hit;

  assign boot_mode = ~valid[0];

  for (genvar g = 0; g < NSEL; g++) begin : g_cmp
    assign raw_hit[g] = valid[g] && in_range(upper, base[g], mask[g]);
    if (g == 0) begin : g_boot
      assign eff_hit[g] = boot_mode | raw_hit[g];
    end else begin : g_lock
      assign eff_hit[g] = ~boot_mode & raw_hit[g];
    end
  end

  assign hit_any = |eff_hit;

  always_comb begin
    hit_idx = '0;
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (eff_hit[i]) hit_idx = SW'(i);
    end
  end

endmodule

// File: rtl/csd_cycle.sv
module csd_cycle
  import csd_pkg::*;
#(
  parameter int NSEL = 8,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_start,
  input  logic            xfer_read,
  input  logic [1:0]      xfer_size,
  input  logic [1:0]      addr_lo,
  input  logic            hit_any,
  input  logic [SW-1:0]   hit_idx,
  input  sel_ctrl_t       hit_ctrl,
  input  logic            ext_ack,
  output logic [NSEL-1:0] cs_n,
  output logic [3:0]      be_n,
  output logic [1:0]      lane_size,
  output logic            ack,
  output logic            launch
);

  logic       busy;
  logic [3:0] wait_cnt;
  logic       auto_q;
  logic       count_done;

  assign launch     = xfer_start && !busy && hit_any;
  assign count_done = (wait_cnt == '0);
  assign ack        = busy && (auto_q ? count_done : ext_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wait_cnt  <= '0;
      auto_q    <= 1'b0;
      cs_n      <= '1;
      be_n      <= '1;
      lane_size <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      wait_cnt  <= hit_ctrl.waits;
      auto_q    <= hit_ctrl.auto_ack;
      cs_n      <= ~(NSEL'(1) << hit_idx);
      be_n      <= (xfer_read && !hit_ctrl.be_on_read) ? 4'hF :
                   ~lane_mask(hit_ctrl.width, xfer_size, addr_lo);
      lane_size <= width_code(hit_ctrl.width);
    end else if (ack) begin
      busy      <= 1'b0;
      cs_n      <= '1;
      be_n      <= '1;
      lane_size <= '0;
    end else if (busy && !count_done) begin
      wait_cnt  <= wait_cnt - 4'd1;
    end
  end

endmodule

// File: rtl/csel_boot_decoder.sv
module csel_boot_decoder
  import csd_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int AW   = 32,
  parameter int BW   = 16,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      strap_d,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [1:0]      cfg_field,
  input  logic [31:0]     cfg_wdata,
  input  logic            xfer_start,
  input  logic            xfer_read,
  input  logic [1:0]      xfer_size,
  input  logic [AW-1:0]   xfer_addr,
  input  logic            ext_ack,
  output logic [NSEL-1:0] cs_n,
  output logic [3:0]      be_n,
  output logic [1:0]      lane_size,
  output logic            ack
);

  logic [NSEL-1:0][BW-1:0] base;
  logic [NSEL-1:0][BW-1:0] mask;
  logic [NSEL-1:0]         valid;
  sel_ctrl_t [NSEL-1:0]    ctrl;
  logic                    hit_any;
  logic [SW-1:0]           hit_idx;
  logic                    boot_mode;
  logic                    launch;
  sel_ctrl_t               hit_ctrl;

  csd_regs #(.NSEL(NSEL), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_d(strap_d),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata),
    .base(base), .mask(mask), .valid(valid), .ctrl(ctrl)
  );

  csd_match #(.NSEL(NSEL), .BW(BW)) u_match (
    .upper(xfer_addr[AW-1 -: BW]), .base(base), .mask(mask),
    .valid(valid), .hit_any(hit_any), .hit_idx(hit_idx),
    .boot_mode(boot_mode)
  );

  assign hit_ctrl = ctrl[hit_idx];

  csd_cycle #(.NSEL(NSEL)) u_cycle (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .xfer_read(xfer_read), .xfer_size(xfer_size),
    .addr_lo(xfer_addr[1:0]), .hit_any(hit_any), .hit_idx(hit_idx),
    .hit_ctrl(hit_ctrl), .ext_ack(ext_ack), .cs_n(cs_n), .be_n(be_n),
    .lane_size(lane_size), .ack(ack), .launch(launch)
  );

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int NSEL = 8,
  parameter int BW   = 16,
  localparam int SW  = $clog2(NSEL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [SW-1:0]   cfg_sel,
  input logic [1:0]      cfg_field,
  input logic [31:0]     cfg_wdata,
  input logic [NSEL-1:0] cs_n,
  input logic [3:0]      be_n,
  input logic            ack,
  input logic            launch,
  input logic            boot_mode
);

  logic v0_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) v0_seen <= 1'b0;
    else if (cfg_we && cfg_sel == '0 && cfg_field == 2'd1) v0_seen <= cfg_wdata[BW];
  end

  assert_boot_global_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && boot_mode) |=> !cs_n[0]);

  assert_boot_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !v0_seen |-> (&cs_n[NSEL-1:1]));

  assert_flag_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode == !v0_seen);

  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_release_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (&cs_n && &be_n));

  assert_ack_in_transfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !(&cs_n));

  assert_be_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (&be_n));

endmodule

bind csel_boot_decoder csd_checker #(.NSEL(NSEL), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cs_n(cs_n), .be_n(be_n),
  .ack(ack), .launch(launch), .boot_mode(boot_mode)
);

// File: tb/csel_boot_decoder_test.sv
module csel_boot_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  strap_d = 8'h00;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_start = 1'b0;
  logic        xfer_read = 1'b0;
  logic [1:0]  xfer_size = '0;
  logic [31:0] xfer_addr = '0;
  logic        ext_ack = 1'b0;
  logic [7:0]  cs_n;
  logic [3:0]  be_n;
  logic [1:0]  lane_size;
  logic        ack;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csel_boot_decoder uut (
    .clk(clk), .rst_n(rst_n), .strap_d(strap_d), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_size(xfer_size),
    .xfer_addr(xfer_addr), .ext_ack(ext_ack), .cs_n(cs_n), .be_n(be_n),
    .lane_size(lane_size), .ack(ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // arithmetic restatement of the lane rule
  function automatic logic [3:0] exp_lanes(input int width, input int xs, input int a);
    int pb, xb, first;
    logic [3:0] m;
    pb = (width == 1) ? 1 : (width == 2) ? 2 : 4;
    xb = (xs == 1) ? 1 : (xs == 2) ? 2 : 4;
    if (xb > pb) xb = pb;
    first = ((a % pb) / xb) * xb;
    m = '0;
    for (int i = 0; i < 4; i++) if (i >= first && i < first + xb) m[i] = 1'b1;
    return m;
  endfunction

  task automatic do_reset(input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_d = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int sel, input int field, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_field = 2'(field); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // exp_wait < 0 means the transfer is closed by ext_ack after 3 clocks
  task automatic access(input logic [31:0] a, input logic rd, input logic [1:0] xs,
                        input int exp_sel, input int exp_wait,
                        input logic [3:0] exp_ben, input logic [1:0] exp_lane,
                        input string tag);
    int k;
    bit got;
    logic [7:0] want;
    @(negedge clk);
    xfer_addr = a; xfer_read = rd; xfer_size = xs; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    if (exp_sel < 0) begin
      repeat (3) begin
        check(cs_n == 8'hFF && !ack, tag, {23'd0, ack, cs_n}, 32'h0FF);
        @(negedge clk);
      end
      return;
    end
    want = ~(8'd1 << exp_sel);
    check(cs_n == want, tag, {24'd0, cs_n}, {24'd0, want});
    check(be_n == exp_ben, tag, {28'd0, be_n}, {28'd0, exp_ben});
    check(lane_size == exp_lane, tag, {30'd0, lane_size}, {30'd0, exp_lane});
    k = 0; got = 0;
    while (k < 40 && !got) begin
      if (exp_wait < 0 && k == 3) begin ext_ack = 1'b1; #1; end
      if (ack) got = 1;
      else begin
        if (cs_n != want) check(0, tag, {24'd0, cs_n}, {24'd0, want});
        @(negedge clk);
        k++;
      end
    end
    check(got && k == ((exp_wait < 0) ? 3 : exp_wait), {tag, " wait"}, k,
          (exp_wait < 0) ? 3 : exp_wait);
    @(negedge clk);
    ext_ack = 1'b0;
    check(cs_n == 8'hFF && be_n == 4'hF && !ack, {tag, " release"},
          {19'd0, ack, be_n, cs_n}, 32'hFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state
    do_reset(8'h88);
    check(cs_n == 8'hFF && be_n == 4'hF && !ack, "R1 reset",
          {19'd0, ack, be_n, cs_n}, 32'hFFF);

    // R6 R7 R8: every strap combination drives select 0 in boot mode
    for (int s = 0; s < 16; s++) begin
      logic [7:0] sb;
      logic [1:0] w;
      logic [3:0] eb;
      sb = {s[3], s[2:1], 1'b0, s[0], 3'b000};
      w  = s[2:1];
      eb = s[0] ? ~exp_lanes(int'(w), 0, 0) : 4'hF;
      do_reset(sb);
      access(32'h1234_5678, 1'b1, 2'b00, 0, s[3] ? 15 : -1, eb,
             (w == 2'b11) ? 2'b00 : w, "R6 strap");
    end

    do_reset(8'h88);
    // R1: any address goes to select 0 while boot mode lasts
    access(32'hF000_0000, 1'b0, 2'b00, 0, 15, 4'h0, 2'b00, "R1 boot");
    // R2: select 1 configured and valid, still locked
    cfg(1, 0, 32'h0000_0100);
    cfg(1, 1, 32'h0001_00FF);
    cfg(1, 2, 32'h0000_001C);
    access(32'h0100_0000, 1'b0, 2'b00, 0, 15, 4'h0, 2'b00, "R2 locked");

    // R5 R3: open select 0 and program 2..7
    cfg(0, 0, 32'h0000_0000);
    cfg(0, 2, 32'h0000_000C);
    cfg(0, 1, 32'h0001_00FF);
    for (int i = 2; i < 8; i++) begin
      cfg(i, 0, 32'(i << 8));
      cfg(i, 1, 32'h0001_00FF);
      cfg(i, 2, 32'((i << 4) | 12));
    end
    for (int t = 0; t < 12; t++) begin
      logic [31:0] a;
      a = {8'(t), 8'(t * 37), 16'h0000};
      if (t < 8) access(a, 1'b0, 2'b00, t, t, 4'h0, 2'b00, "R3 decode");
      else       access(a, 1'b0, 2'b00, -1, 0, 4'hF, 2'b00, "R3 miss");
    end

    // R4: select 5 matches everything, lower numbers keep priority
    cfg(5, 1, 32'h0001_FFFF);
    access(32'h0A00_0000, 1'b0, 2'b00, 5, 5, 4'h0, 2'b00, "R4 wide");
    access(32'h0300_0000, 1'b0, 2'b00, 3, 3, 4'h0, 2'b00, "R4 prio");
    access(32'h0700_0000, 1'b0, 2'b00, 5, 5, 4'h0, 2'b00, "R4 prio");
    cfg(5, 1, 32'h0000_00FF);
    access(32'h0500_0000, 1'b0, 2'b00, -1, 0, 4'hF, 2'b00, "R3 invalid");

    // R9: wait-state sweep on select 1
    for (int w = 0; w < 16; w++) begin
      cfg(1, 2, 32'((w << 4) | 12));
      access(32'h0100_0004, 1'b0, 2'b00, 1, w, 4'h0, 2'b00, "R9 waits");
    end

    // R7 R8: lane sweep on select 2
    for (int w = 0; w < 4; w++)
      for (int bm = 0; bm < 2; bm++) begin
        cfg(2, 2, 32'((bm << 2) | w | 8));
        for (int xs = 0; xs < 3; xs++)
          for (int a = 0; a < 4; a++)
            for (int rd = 0; rd < 2; rd++) begin
              logic [3:0] eb;
              eb = (rd == 1 && bm == 0) ? 4'hF : ~exp_lanes(w, xs, a);
              access(32'h0200_0000 + 32'(a), 1'(rd), 2'(xs), 2, 0, eb,
                     (w == 3) ? 2'b00 : 2'(w), "R8 lanes");
            end
      end

    // R11: second start during a transfer is ignored
    begin
      int k;
      bit got;
      @(negedge clk);
      xfer_addr = 32'h0300_0000; xfer_read = 1'b0; xfer_size = 2'b00;
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      k = 0; got = 0;
      while (k < 40 && !got) begin
        if (k == 1) begin xfer_addr = 32'h0100_0000; xfer_start = 1'b1; end
        if (k == 2) xfer_start = 1'b0;
        if (ack) got = 1;
        else begin
          if (cs_n != 8'hF7) check(0, "R11 busy", {24'd0, cs_n}, 32'hF7);
          @(negedge clk);
          k++;
        end
      end
      check(got && k == 3, "R11 busy wait", k, 3);
      @(negedge clk);
      check(cs_n == 8'hFF, "R11 busy release", {24'd0, cs_n}, 32'hFF);
    end

    // R10: external acknowledge on select 4
    cfg(4, 2, 32'h0000_0004);
    @(negedge clk); ext_ack = 1'b1;
    @(negedge clk);
    check(!ack, "R10 idle", {31'd0, ack}, 0);
    @(negedge clk); ext_ack = 1'b0;
    access(32'h0400_0000, 1'b0, 2'b00, 4, -1, 4'h0, 2'b00, "R10 ext");

    finish_run();
  end

endmodule